// File: doc/BRIEF.md
# Multi-Bank Page Interleave Tracker

This block sits between a memory requester and a group of up to four DRAM banks and keeps track of which page is open in each bank. Consecutive pages are spread over the banks in rotation: the low bits of the page number pick the bank, and the rest of the page number is the row held open in that bank. Because each bank keeps its own row open, an access pattern that alternates between two regions, such as instruction fetches and data loads, can hit open pages in two different banks instead of closing and reopening one page each time.

Each cycle the requester may present one address. One cycle later the block reports whether the access hit the open row of its bank. It also drives each bank's own active-low row strobe and column strobe. A miss closes and reopens only the row of the bank it addresses. A configuration input selects one-way, two-way or four-way interleave, to match how much memory is fitted. Changing that input closes every open page. Two saturating counters tally hits and misses so that the hit rate of a traffic pattern can be measured.

Top module: `page_interleave_tracker`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `resp_valid` is 0, every bit of `ras_n` and `cas_n` is 1, and both counters read 0.
- R2: Address bits [COL_W-1:0] are the column and the bits above them form the page number. Let k be 0, 1 or 2 for `ways_cfg` 2'b00, 2'b01, or 2'b10/2'b11. The bank is the low k bits of the page number, and the row is the page number shifted right by k. `resp_bank`, `resp_row` and `resp_col` show these values in the cycle after `req_valid` is high. `resp_valid` follows `req_valid` with one cycle of delay.
- R3: `resp_hit` is 1 only when the addressed bank holds an open page whose row equals the request's row. The first access to any bank after reset is a miss.
- R4: A miss makes the requested row the open row of its bank only. The open rows of all other banks stay as they were, so alternating between pages that map to different banks gives hits after the first touch of each.
- R5: In a response cycle for a hit, `cas_n` is low for the addressed bank only. In a response cycle for a miss, both `ras_n` and `cas_n` of the addressed bank are high (row close). In the following cycle that bank's `ras_n` is low.
- R6: Outside a miss close cycle, `ras_n[b]` is low exactly when bank b holds an open page. The block never drives more than one `cas_n` bit low at a time, and never drives `cas_n[b]` low while `ras_n[b]` is high.
- R7: A cycle in which `ways_cfg` differs from its value in the previous cycle closes every open page. A request in that cycle is a miss, and in the next cycle all `ras_n` bits are high.
- R8: `hit_count` and `miss_count` each add one for every hit or miss response, in the same cycle the response appears. Each counter stops at 2^CNT_W-1.
- R9: In one-way mode every request goes to bank 0, and banks 1 to 3 keep `ras_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ways_cfg | input | 2 | Interleave: 00 one-way, 01 two-way, 1x four-way |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_hit | output | 1 | The request hit an open page |
| resp_bank | output | 2 | Bank index of the request |
| resp_row | output | ADDR_W-COL_W | Row of the request within its bank |
| resp_col | output | COL_W | Column of the request |
| ras_n | output | 4 | Per-bank row strobe, active low |
| cas_n | output | 4 | Per-bank column strobe, active low |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
The checker tests the strobe rules on every cycle. These are: at most one column strobe active, never a column strobe without its row strobe, a column strobe on every hit, and a row close on every miss. It also tests the one-cycle response timing, all row strobes high after a configuration change, counter stepping, and that one-way traffic uses only bank 0. Whether a hit is correct depends on the history of open rows in every bank. So the address decode, the isolation of a miss to one bank, and the hit rates for alternating patterns are shown only by the bench scenarios, which compare against a reference model of the open rows.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int BANK_W    = 2;
  localparam int NUM_BANKS = 1 << BANK_W;

  typedef enum logic [1:0] {
    WAYS_ONE  = 2'b00,
    WAYS_TWO  = 2'b01,
    WAYS_FOUR = 2'b10
  } ways_e;

  // number of page-number bits used as bank index
  function automatic logic [1:0] bank_bits(input logic [1:0] cfg);
    case (cfg)
      WAYS_ONE: return 2'd0;
      WAYS_TWO: return 2'd1;
      default:  return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/pit_decode.sv
module pit_decode
  import pit_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int COL_W  = 8,
  localparam int PAGE_W = ADDR_W - COL_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         cfg,
  output logic [BANK_W-1:0]  bank,
  output logic [PAGE_W-1:0]  row,
  output logic [COL_W-1:0]   col
);
  logic [PAGE_W-1:0] page;
  logic [1:0]        k;
  logic [PAGE_W-1:0] mask;

  always_comb begin
    page = addr[ADDR_W-1:COL_W];
    col  = addr[COL_W-1:0];
    k    = bank_bits(cfg);
    mask = (PAGE_W'(1) << k) - PAGE_W'(1);
    row  = page >> k;
    bank = BANK_W'(page & mask);
  end
endmodule

// File: rtl/pit_bank_state.sv
module pit_bank_state
  import pit_pkg::*;
#(
  parameter int ROW_W = 12
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            flush,
  input  logic [NUM_BANKS-1:0]            load,
  input  logic [ROW_W-1:0]                load_row,
  output logic [NUM_BANKS-1:0]            open_q,
  output logic [NUM_BANKS-1:0][ROW_W-1:0] row_q
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (load[b]) begin
        open_q[b] <= 1'b1;
        row_q[b]  <= load_row;
      end else if (flush) begin
        open_q[b] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pit_stats.sv
module pit_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_ev,
  input  logic             miss_ev,
  output logic [CNT_W-1:0] hits,
  output logic [CNT_W-1:0] misses
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      hits   <= '0;
      misses <= '0;
    end else begin
      if (hit_ev && hits != TOP)    hits   <= hits + 1'b1;
      if (miss_ev && misses != TOP) misses <= misses + 1'b1;
    end
  end
endmodule

// File: rtl/page_interleave_tracker.sv
module page_interleave_tracker
  import pit_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int COL_W  = 8,
  parameter int CNT_W  = 16,
  localparam int ROW_W = ADDR_W - COL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           ways_cfg,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 resp_valid,
  output logic                 resp_hit,
  output logic [BANK_W-1:0]    resp_bank,
  output logic [ROW_W-1:0]     resp_row,
  output logic [COL_W-1:0]     resp_col,
  output logic [NUM_BANKS-1:0] ras_n,
  output logic [NUM_BANKS-1:0] cas_n,
  output logic [CNT_W-1:0]     hit_count,
  output logic [CNT_W-1:0]     miss_count
);
  logic [BANK_W-1:0]            dec_bank;
  logic [ROW_W-1:0]             dec_row;
  logic [COL_W-1:0]             dec_col;
  logic [1:0]                   cfg_q;
  logic                         flush;
  logic [NUM_BANKS-1:0]         open_q, open_eff, open_nxt, load, sel;
  logic [NUM_BANKS-1:0][ROW_W-1:0] row_q;
  logic                         hit, miss;

  pit_decode #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_dec (
    .addr(req_addr), .cfg(ways_cfg),
    .bank(dec_bank), .row(dec_row), .col(dec_col)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= ways_cfg;
    else     cfg_q <= ways_cfg;
  end

  always_comb begin
    flush    = !rst && (ways_cfg != cfg_q);
    open_eff = flush ? '0 : open_q;
    sel      = req_valid ? (NUM_BANKS'(1) << dec_bank) : '0;
    hit      = req_valid && open_eff[dec_bank] && (row_q[dec_bank] == dec_row);
    miss     = req_valid && !hit;
    load     = miss ? sel : '0;
    open_nxt = open_eff | load;
  end

  pit_bank_state #(.ROW_W(ROW_W)) u_state (
    .clk(clk), .rst(rst), .flush(flush),
    .load(load), .load_row(dec_row),
    .open_q(open_q), .row_q(row_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_bank  <= '0;
      resp_row   <= '0;
      resp_col   <= '0;
      ras_n      <= '1;
      cas_n      <= '1;
    end else begin
      resp_valid <= req_valid;
      resp_hit   <= hit;
      resp_bank  <= dec_bank;
      resp_row   <= dec_row;
      resp_col   <= dec_col;
      ras_n      <= ~open_nxt | (miss ? sel : '0);
      cas_n      <= ~(hit ? sel : '0);
    end
  end

  pit_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst(rst), .hit_ev(hit), .miss_ev(miss),
    .hits(hit_count), .misses(miss_count)
  );
endmodule

// File: rtl/pit_checker.sv
module pit_checker
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           ways_cfg,
  input logic                 req_valid,
  input logic                 resp_valid,
  input logic                 resp_hit,
  input logic [BANK_W-1:0]    resp_bank,
  input logic [NUM_BANKS-1:0] ras_n,
  input logic [NUM_BANKS-1:0] cas_n,
  input logic [CNT_W-1:0]     hit_count,
  input logic [CNT_W-1:0]     miss_count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  logic [1:0] cfg_seen;
  logic       armed;

  always_ff @(posedge clk) begin
    cfg_seen <= ways_cfg;
    armed    <= !rst;
  end

  AST_ONE_CAS: assert property (@(posedge clk) disable iff (rst)
    $countones(~cas_n) <= 1) else $error("one cas"); // R6
  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (rst)
    ((~cas_n) & ras_n) == '0) else $error("cas without ras"); // R6
  AST_RESP_TIMING: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid) else $error("resp timing"); // R2
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid) else $error("spurious resp"); // R2
  AST_HIT_STROBE: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> !cas_n[resp_bank]) else $error("hit strobe"); // R5
  AST_MISS_CLOSE: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> (ras_n[resp_bank] && cas_n[resp_bank])) else $error("miss close"); // R5
  AST_CFG_FLUSH: assert property (@(posedge clk) disable iff (rst || !armed)
    (ways_cfg != cfg_seen) |=> (&ras_n)) else $error("cfg flush"); // R7
  AST_HIT_STEP: assert property (@(posedge clk) disable iff (rst || !armed)
    (resp_valid && resp_hit && $past(hit_count) != TOP) |-> hit_count == $past(hit_count) + 1'b1)
    else $error("hit step"); // R8
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (rst || !armed)
    (resp_valid && !resp_hit && $past(miss_count) != TOP) |-> miss_count == $past(miss_count) + 1'b1)
    else $error("miss step"); // R8
  AST_ONEWAY_BANK0: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ways_cfg == WAYS_ONE) |=> resp_bank == '0) else $error("one-way bank"); // R9
endmodule

bind page_interleave_tracker pit_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ways_cfg(ways_cfg), .req_valid(req_valid),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_bank(resp_bank),
  .ras_n(ras_n), .cas_n(cas_n), .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/tb_page_interleave_tracker.sv
module tb_page_interleave_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;
  localparam int COL_W  = 8;
  localparam int CNT_W  = 6;
  localparam int ROW_W  = ADDR_W - COL_W;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] ways_cfg;
  logic req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic resp_valid, resp_hit;
  logic [1:0] resp_bank;
  logic [ROW_W-1:0] resp_row;
  logic [COL_W-1:0] resp_col;
  logic [3:0] ras_n, cas_n;
  logic [CNT_W-1:0] hit_count, miss_count;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit             m_open [4];
  bit [ROW_W-1:0] m_row  [4];
  bit [1:0]       m_cfg;
  int             m_hits, m_miss;
  int             run_hits;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_interleave_tracker #(.ADDR_W(ADDR_W), .COL_W(COL_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .ways_cfg(ways_cfg), .req_valid(req_valid), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_bank(resp_bank), .resp_row(resp_row),
    .resp_col(resp_col), .ras_n(ras_n), .cas_n(cas_n),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int kbits(input bit [1:0] cfg);
    return (cfg == 2'b00) ? 0 : (cfg == 2'b01) ? 1 : 2;
  endfunction

  function automatic [ADDR_W-1:0] mk(input int page, input int col);
    return {ROW_W'(page), COL_W'(col)};
  endfunction

  task automatic reset_model(input bit [1:0] cfg);
    for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = '0; end
    m_cfg = cfg; m_hits = 0; m_miss = 0;
  endtask

  // one cycle: drive, predict, check
  task automatic step(input bit v, input [ADDR_W-1:0] a, input bit [1:0] cfg, input string tag);
    int k, bank;
    bit [ROW_W-1:0] page, row;
    bit hit, miss;
    bit [3:0] e_ras, e_cas;
    @(negedge clk);
    ways_cfg = cfg; req_valid = v; req_addr = a;
    if (cfg != m_cfg) for (int b = 0; b < 4; b++) m_open[b] = 0;
    m_cfg = cfg;
    k = kbits(cfg);
    page = a[ADDR_W-1:COL_W];
    bank = int'(page) & ((1 << k) - 1);
    row = page >> k;
    hit = v && m_open[bank] && m_row[bank] == row;
    miss = v && !hit;
    if (miss) begin m_open[bank] = 1; m_row[bank] = row; end
    if (hit && m_hits < 63) m_hits++;
    if (miss && m_miss < 63) m_miss++;
    run_hits += hit;
    for (int b = 0; b < 4; b++) begin
      e_ras[b] = !m_open[b] || (miss && b == bank);
      e_cas[b] = !(hit && b == bank);
    end
    @(posedge clk); #(CLK_PERIOD/4);
    check({tag, " R2 valid"}, resp_valid, v);
    if (v) begin
      check({tag, " R3 hit"}, resp_hit, hit);
      check({tag, " R2 bank"}, resp_bank, bank);
      check({tag, " R2 row"}, resp_row, row);
      check({tag, " R2 col"}, resp_col, a[COL_W-1:0]);
    end
    check({tag, " R5 R6 ras_n"}, ras_n, e_ras);
    check({tag, " R5 cas_n"}, cas_n, e_cas);
    check({tag, " R8 hits"}, hit_count, m_hits);
    check({tag, " R8 misses"}, miss_count, m_miss);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst = 1; ways_cfg = 2'b10; req_valid = 0; req_addr = '0;
    reset_model(2'b10);
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1 reset resp_valid", resp_valid, 0);
    check("R1 reset ras_n", ras_n, 4'hF);
    check("R1 reset cas_n", cas_n, 4'hF);
    check("R1 reset hits", hit_count, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #(CLK_PERIOD/4);
    check("R1 after reset ras_n", ras_n, 4'hF);
    check("R1 after reset misses", miss_count, 0);

    // R3 first touch misses, second hits
    step(1, mk(5, 3), 2'b10, "R3 first");
    step(1, mk(5, 9), 2'b10, "R3 same page");
    // R4 four-way rotation: pages 8..11 then repeat
    for (int p = 8; p < 12; p++) step(1, mk(p, p), 2'b10, "R4 rotate");
    run_hits = 0;
    for (int p = 8; p < 12; p++) step(1, mk(p, 1), 2'b10, "R4 revisit");
    check("R4 four open pages all hit", run_hits, 4);
    // R4 miss on bank 0 leaves others open
    step(1, mk(40, 0), 2'b10, "R4 replace bank0");
    run_hits = 0;
    for (int p = 9; p < 12; p++) step(1, mk(p, 2), 2'b10, "R4 neighbours");
    check("R4 neighbours kept", run_hits, 3);
    step(0, '0, 2'b10, "R5 idle after");
    // R4 two-way code/data alternation
    step(1, mk(20, 0), 2'b01, "R7 cfg change miss");
    step(1, mk(21, 0), 2'b01, "R4 2way data");
    run_hits = 0;
    for (int i = 0; i < 6; i++) step(1, mk(20 + (i % 2), i), 2'b01, "R4 2way alt");
    check("R4 two-way alternation hit rate", run_hits, 6);
    // R9 one-way alternation thrashes bank 0
    run_hits = 0;
    for (int i = 0; i < 6; i++) step(1, mk(20 + (i % 2), i), 2'b00, "R9 1way alt");
    check("R9 one-way alternation hits", run_hits, 0);
    step(0, '0, 2'b00, "R9 idle");
    check("R9 banks1-3 closed", ras_n[3:1], 3'b111);
    // R7 config change with no request closes all
    step(0, '0, 2'b10, "R7 flush idle");
    check("R7 all ras high", ras_n, 4'hF);
    // random mix, counters saturate along the way (R8)
    for (int i = 0; i < 400; i++) begin
      bit [1:0] c;
      c = ($urandom % 40 == 0) ? 2'($urandom) : m_cfg;
      step(($urandom % 5) != 0, mk($urandom % 10, $urandom), c, "RND");
    end
    check("R8 hits saturated", hit_count, 63);
    check("R8 misses saturated", miss_count, 63);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule